// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block generates the four handshake interrupts that let a host processor and a board processor exchange messages through a shared dual-port memory. It watches the access strobes and address buses that each side presents to the memory. It also watches four active-low request and acknowledge pins driven by the board processor. From these it holds four active-low interrupt flags: two that tell the board about host traffic, and two that tell the host about board traffic.

Each flag is set by one kind of event and cleared by another event that comes from the opposite side. A host write into the lower mailbox page (top address nibble 0x7) or a host read from the upper mailbox page (top nibble 0xB) raises a board-facing flag. The board drops that flag with a qualified acknowledge pulse. In the other direction, a qualified request pulse from the board raises a host-facing flag. The host clears it by writing the upper page, and the board clears it by reading the lower page. All asynchronous inputs pass through multi-flop synchronizers. A pin pulse is accepted only after it has stayed low for `PULSE_MIN` block clocks. Each strobe or pulse yields exactly one event, so every flag makes a single clean falling edge per handshake.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four interrupt outputs are driven high after that edge.
- R2: A host write strobe (`host_wr_n` low) whose address has top nibble 0x7 drives `irq_hwr_n` low. A host write to any other top nibble leaves `irq_hwr_n` unchanged.
- R3: A low pulse of at least `PULSE_MIN` clocks on `ack_hwr_n` drives `irq_hwr_n` high.
- R4: A host read strobe (`host_rd_n` low) whose address has top nibble 0xB drives `irq_hrd_n` low, and any other nibble leaves it unchanged. A qualified low pulse on `ack_hrd_n` drives it high.
- R5: A qualified low pulse on `req_bwr_n` drives `irq_bwr_n` low. A host write with top nibble 0xB drives it high, and a host write to any other nibble leaves it unchanged.
- R6: A qualified low pulse on `req_brd_n` drives `irq_brd_n` low. A board read strobe (`brd_rd_n` low) with top nibble 0x7 drives it high, and a board read of any other nibble leaves it unchanged.
- R7: A low pulse on any of the four pins that lasts fewer than `PULSE_MIN` clocks has no effect on any output.
- R8: One low interval on a pin produces exactly one event. A request pin held low after its flag has been cleared does not set the flag again until the pin goes high and then pulses again.
- R9: When the set event and the clear event of one flag land in the same cycle, the flag is driven low (set wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | ADDR_W | Host-side memory address, held stable while a host strobe is low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| brd_addr | input | ADDR_W | Board-side memory address, held stable while the board strobe is low |
| brd_rd_n | input | 1 | Board read strobe, active low |
| ack_hwr_n | input | 1 | Board acknowledge for the host-write flag, active-low pulse |
| ack_hrd_n | input | 1 | Board acknowledge for the host-read flag, active-low pulse |
| req_bwr_n | input | 1 | Board write-done request to the host, active-low pulse |
| req_brd_n | input | 1 | Board read-done request to the host, active-low pulse |
| irq_hwr_n | output | 1 | Host-write interrupt to the board, active low |
| irq_hrd_n | output | 1 | Host-read interrupt to the board, active low |
| irq_bwr_n | output | 1 | Board-write interrupt to the host, active low |
| irq_brd_n | output | 1 | Board-read interrupt to the host, active low |

## Verification
On every cycle the assertions check the following:
- Each flag responds to its qualified set and clear events.
- Set wins when both arrive together.
- A flag holds when neither event occurs.
- Every qualifier and strobe detector emits single-cycle events.
- Reset drives all outputs high.

Some behaviour can only be shown by the bench's scenarios, because it depends on how events are routed to the pins and windows:
- the page decode of every address nibble for each strobe;
- the rejection of pulses one clock shorter than the minimum;
- a request held low across a clear;
- the exact cycle alignment at which set and clear collide. The bench finds this by sweeping the offset between a request pulse and a clearing host write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Channel index, shared by the flag array and the pin array.
   typedef enum logic [1:0] {
      CH_HWR = 2'd0,   // host wrote the lower page
      CH_HRD = 2'd1,   // host read the upper page
      CH_BWR = 2'd2,   // board signals write done
      CH_BRD = 2'd3    // board signals read done
   } mbx_ch_e;

   localparam int NUM_CH = 4;

   // True when the sampled page nibble selects the given window.
   function automatic logic page_hit(input logic [3:0] page, input logic [3:0] win);
      return page == win;
   endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mbx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_pulse_qual.sv
module mbx_pulse_qual #(
   parameter int MIN_LOW = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s_n,     // synchronized active-low pin
   output logic evt      // one cycle, on the MIN_LOW-th low cycle
);

   if (MIN_LOW < 1) begin : g_bad_min
      $error("mbx_pulse_qual: MIN_LOW must be at least 1");
   end

   localparam int CW = $clog2(MIN_LOW + 1);
   localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);
   localparam logic [CW-1:0] SAT  = CW'(MIN_LOW);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || s_n)      run_cnt <= '0;
      else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
   end

   assign evt = !s_n && (run_cnt == LAST);

   // R8
   single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

endmodule

// File: rtl/mbx_access_det.sv
module mbx_access_det #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 4,
   parameter int SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              evt,
   output logic [PAGE_W-1:0] page
);

   if (PAGE_W > ADDR_W) begin : g_bad_page
      $error("mbx_access_det: PAGE_W exceeds ADDR_W");
   end

   logic s_n, s_prev;

   mbx_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(strobe_n), .q(s_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) s_prev <= 1'b1;
      else        s_prev <= s_n;
   end

   assign evt  = s_prev && !s_n;
   assign page = addr[ADDR_W-1 -: PAGE_W];

   logic unused_low;
   if (PAGE_W < ADDR_W) begin : g_low
      assign unused_low = ^addr[ADDR_W-PAGE_W-1:0];
   end else begin : g_nolow
      assign unused_low = 1'b0;
   end

   // R2
   acc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);

   always_ff @(posedge clk) begin
      if (!rst_n)   irq_n <= 1'b1;
      else if (set) irq_n <= 1'b0;
      else if (clr) irq_n <= 1'b1;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> !irq_n);

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> irq_n);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
   parameter int          ADDR_W    = 16,
   parameter int          PAGE_W    = 4,
   parameter logic [3:0]  LO_PAGE   = 4'h7,
   parameter logic [3:0]  HI_PAGE   = 4'hB,
   parameter int          SYNC      = 2,
   parameter int          PULSE_MIN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr_n,
   input  logic              host_rd_n,
   input  logic [ADDR_W-1:0] brd_addr,
   input  logic              brd_rd_n,
   input  logic              ack_hwr_n,
   input  logic              ack_hrd_n,
   input  logic              req_bwr_n,
   input  logic              req_brd_n,
   output logic              irq_hwr_n,
   output logic              irq_hrd_n,
   output logic              irq_bwr_n,
   output logic              irq_brd_n
);
   import mbx_pkg::*;

   if (PAGE_W != 4) begin : g_bad_pw
      $error("mbx_irq_ctrl: page decode expects a 4-bit nibble");
   end
   if (ADDR_W < PAGE_W) begin : g_bad_aw
      $error("mbx_irq_ctrl: ADDR_W too small");
   end
   if (LO_PAGE == HI_PAGE) begin : g_bad_win
      $error("mbx_irq_ctrl: windows must differ");
   end

   // Pin qualification, one lane per channel.
   logic [NUM_CH-1:0] pin_n, pin_s_n, pin_evt;
   assign pin_n[CH_HWR] = ack_hwr_n;
   assign pin_n[CH_HRD] = ack_hrd_n;
   assign pin_n[CH_BWR] = req_bwr_n;
   assign pin_n[CH_BRD] = req_brd_n;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
      mbx_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_n[i]), .q(pin_s_n[i])
      );
      mbx_pulse_qual #(.MIN_LOW(PULSE_MIN)) u_qual (
         .clk(clk), .rst_n(rst_n), .s_n(pin_s_n[i]), .evt(pin_evt[i])
      );
   end

   // Memory access detection.
   logic              hw_evt, hr_evt, br_evt;
   logic [PAGE_W-1:0] hw_page, hr_page, br_page;

   mbx_access_det #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC(SYNC)) u_hwr (
      .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n), .addr(host_addr),
      .evt(hw_evt), .page(hw_page)
   );
   mbx_access_det #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC(SYNC)) u_hrd (
      .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n), .addr(host_addr),
      .evt(hr_evt), .page(hr_page)
   );
   mbx_access_det #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC(SYNC)) u_brd (
      .clk(clk), .rst_n(rst_n), .strobe_n(brd_rd_n), .addr(brd_addr),
      .evt(br_evt), .page(br_page)
   );

   // Set and clear routing.
   logic [NUM_CH-1:0] set_v, clr_v, irq_v;

   always_comb begin
      set_v[CH_HWR] = hw_evt && page_hit(hw_page, LO_PAGE);
      clr_v[CH_HWR] = pin_evt[CH_HWR];
      set_v[CH_HRD] = hr_evt && page_hit(hr_page, HI_PAGE);
      clr_v[CH_HRD] = pin_evt[CH_HRD];
      set_v[CH_BWR] = pin_evt[CH_BWR];
      clr_v[CH_BWR] = hw_evt && page_hit(hw_page, HI_PAGE);
      set_v[CH_BRD] = pin_evt[CH_BRD];
      clr_v[CH_BRD] = br_evt && page_hit(br_page, LO_PAGE);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
      mbx_irq_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set(set_v[c]), .clr(clr_v[c]),
         .irq_n(irq_v[c])
      );
   end

   assign irq_hwr_n = irq_v[CH_HWR];
   assign irq_hrd_n = irq_v[CH_HRD];
   assign irq_bwr_n = irq_v[CH_BWR];
   assign irq_brd_n = irq_v[CH_BRD];

   // R1
   logic rst_q, rst_seen;
   always_ff @(posedge clk) begin
      rst_q    <= !rst_n;
      rst_seen <= 1'b1;
      if (rst_seen && rst_q) begin
         reset_idle_chk: assert (irq_v == '1);
      end
   end

   // R5
   bwr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_bwr_n) |-> $past(pin_evt[CH_BWR]));

   // R6
   brd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_brd_n) |-> $past(br_evt));

endmodule

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;

   localparam int ADDR_W = 16;
   localparam int PMIN   = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0, brd_addr = '0;
   logic              host_wr_n = 1'b1, host_rd_n = 1'b1, brd_rd_n = 1'b1;
   logic [3:0]        pins_n = 4'hF;   // 0 ack_hwr, 1 ack_hrd, 2 req_bwr, 3 req_brd
   logic              irq_hwr_n, irq_hrd_n, irq_bwr_n, irq_brd_n;

   mbx_irq_ctrl #(.ADDR_W(ADDR_W), .PULSE_MIN(PMIN)) uut (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
      .brd_addr(brd_addr), .brd_rd_n(brd_rd_n),
      .ack_hwr_n(pins_n[0]), .ack_hrd_n(pins_n[1]),
      .req_bwr_n(pins_n[2]), .req_brd_n(pins_n[3]),
      .irq_hwr_n(irq_hwr_n), .irq_hrd_n(irq_hrd_n),
      .irq_bwr_n(irq_bwr_n), .irq_brd_n(irq_brd_n)
   );

   int  n_chk = 0, n_bad = 0;
   bit  done  = 1'b0;

   // Outputs packed as {brd, bwr, hrd, hwr}.
   task automatic check(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {irq_brd_n, irq_bwr_n, irq_hrd_n, irq_hwr_n};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: outputs {brd,bwr,hrd,hwr} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (PMIN + 8) @(negedge clk);
   endtask

   task automatic pin_pulse(input int idx, input int len);
      pins_n[idx] = 1'b0;
      repeat (len) @(negedge clk);
      pins_n[idx] = 1'b1;
   endtask

   task automatic host_acc(input bit wr, input logic [3:0] pg);
      host_addr = {pg, 12'h5A3};
      if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      host_wr_n = 1'b1;
      host_rd_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic brd_acc(input logic [3:0] pg);
      brd_addr = {pg, 12'hC3C};
      brd_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      brd_rd_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_all();
      host_acc(1'b1, 4'h7); host_acc(1'b0, 4'hB);
      pin_pulse(2, PMIN);   pin_pulse(3, PMIN);
      settle();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] e;
      @(negedge clk);
      do_reset();
      check("R1 after reset", 4'hF);
      set_all();
      check("R1 all set before reset", 4'h0);
      do_reset();
      check("R1 reset clears all", 4'hF);

      // R2, R5: host write to every page from idle.
      for (int p = 0; p < 16; p++) begin
         do_reset();
         host_acc(1'b1, 4'(p));
         settle();
         e = 4'hF; if (p == 7) e[0] = 1'b0;
         check("R2 host write page sweep", e);
      end
      // R4: host read to every page.
      for (int p = 0; p < 16; p++) begin
         do_reset();
         host_acc(1'b0, 4'(p));
         settle();
         e = 4'hF; if (p == 11) e[1] = 1'b0;
         check("R4 host read page sweep", e);
      end
      // R5: host write to every page while all four are set.
      for (int p = 0; p < 16; p++) begin
         do_reset(); set_all();
         host_acc(1'b1, 4'(p));
         settle();
         e = 4'h0; if (p == 11) e[2] = 1'b1;
         check("R5 host write clears board-write", e);
      end
      // R6: board read to every page while all four are set.
      for (int p = 0; p < 16; p++) begin
         do_reset(); set_all();
         brd_acc(4'(p));
         settle();
         e = 4'h0; if (p == 7) e[3] = 1'b1;
         check("R6 board read clears board-read", e);
      end
      // R3, R4, R5, R6, R7: pulse length sweep on each pin.
      for (int idx = 0; idx < 4; idx++) begin
         for (int len = 1; len <= PMIN + 2; len++) begin
            do_reset();
            if (idx < 2) begin
               set_all();
               pin_pulse(idx, len);
               settle();
               e = 4'h0; if (len >= PMIN) e[idx] = 1'b1;
               check(idx == 0 ? "R3 R7 ack_hwr length" : "R4 R7 ack_hrd length", e);
            end else begin
               pin_pulse(idx, len);
               settle();
               e = 4'hF; if (len >= PMIN) e[idx] = 1'b0;
               check(idx == 2 ? "R5 R7 req_bwr length" : "R6 R7 req_brd length", e);
            end
         end
      end
      // R8: request held low across a clear does not set again.
      do_reset();
      pins_n[2] = 1'b0;
      settle();
      check("R8 held request sets once", 4'hB);
      host_acc(1'b1, 4'hB);
      repeat (3 * PMIN) @(negedge clk);
      check("R8 held request after clear", 4'hF);
      pins_n[2] = 1'b1;
      settle();
      check("R8 release does not set", 4'hF);
      pin_pulse(2, PMIN);
      settle();
      check("R8 fresh pulse sets", 4'hB);
      // R9: offset sweep between request pulse and clearing host write.
      for (int d = 0; d <= 2 * PMIN; d++) begin
         do_reset();
         fork
            pin_pulse(2, PMIN);
            begin
               repeat (d) @(negedge clk);
               host_acc(1'b1, 4'hB);
            end
         join
         settle();
         e = 4'hF; if (d <= PMIN - 1) e[2] = 1'b0;
         check("R9 set versus clear offset", e);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule